// File: doc/BRIEF.md
# Width-Configurable Dual-Clock FIFO Controller

This block manages one on-chip RAM as a first-in first-out queue whose writer and reader run on unrelated clocks. A 3-bit width code chooses the word size, and that choice fixes the depth so that the storage stays the same size. Each side keeps its own binary pointer with one extra wrap bit. A Gray-coded copy of each pointer is handed to the opposite clock domain through a two-flop synchronizer, and there it is turned back into binary and compared.

Each domain drives two registered flags. The write side drives full and almost-full. The read side drives empty and almost-empty. The two "almost" levels come from 8-bit inputs. An asynchronous active-high clear returns both sides to the empty state. The width code and the threshold inputs are expected to change only while clear is high. Read data is registered and is updated on each accepted read.

Top module: `wcfifo`

## Requirements
- R1: While `clr` is high and after it falls, `full` and `afull` are 0, `empty` and `aempty` are 1 and `rdata` is 0. Data written before a clear is never read afterwards.
- R2: The capacity (the number of accepted writes from empty to `full`) is set by `width_code` as follows: 0 gives 4096 words of 1 bit, 1 gives 2048 of 2, 2 gives 1024 of 4, 3 gives 512 of 9, 4 gives 256 of 18, and 5 gives 128 of 36.
- R3: A write presented while `full` is 1 is dropped. It does not change the stored contents or the write pointer.
- R4: A read presented while `empty` is 1 is dropped. `rdata` holds and `empty` stays 1.
- R5: Words come out in the order they were written. `rdata` carries `wdata` bits [w-1:0] for the selected width w, and every bit above w reads as 0.
- R6: `afull` is 1 exactly when the free space seen by the write side (capacity minus occupancy) is at most `af_level`. It changes on the write-clock edge of the write that brings it about.
- R7: `aempty` is 1 exactly when the occupancy seen by the read side is at most `ae_level`. It changes on the read-clock edge of the read that brings it about.
- R8: The reserved codes 6 and 7 behave exactly like code 0.
- R9: After a write into an empty FIFO, `empty` falls within five read-clock rising edges of the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| clr | input | 1 | Asynchronous clear, active high |
| width_code | input | 3 | Word width / depth selection |
| af_level | input | 8 | Free-space threshold for almost-full |
| ae_level | input | 8 | Occupancy threshold for almost-empty |
| wen | input | 1 | Write request |
| wdata | input | 36 | Write word; bits above the selected width are ignored |
| ren | input | 1 | Read request |
| rdata | output | 36 | Registered read word |
| full | output | 1 | No space left (write domain) |
| afull | output | 1 | Free space at or below `af_level` (write domain) |
| empty | output | 1 | Nothing to read (read domain) |
| aempty | output | 1 | Occupancy at or below `ae_level` (read domain) |

## Verification
The hardest state to reach from the ports is a write attempt against a full queue in the deepest modes. To reach it, the bench must push thousands of words through one port while the reader stays idle. The table loop does this for every legal code and for one reserved code. In each case it writes until `full` rises, recording the write count at which `afull` rose, and then forces one extra write carrying junk data. It then waits for the pointers to settle across the domains and drains the queue. The drain proves that no word was lost or added, and it records the read at which `aempty` rose.

// File: rtl/wcf_pkg.sv
package wcf_pkg;

   localparam int unsigned CODE_W = 3;
   localparam int unsigned GRAY_MAX_W = 32;

   // log2 of the depth for a width code; codes above 5 fall back to code 0
   function automatic int unsigned depth_lg(input logic [CODE_W-1:0] code,
                                            input int unsigned addr_w);
      if (code <= 3'd5) return addr_w - int'(code);
      return addr_w;
   endfunction

   function automatic int unsigned word_bits(input logic [CODE_W-1:0] code);
      case (code)
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 9;
         3'd4:    return 18;
         3'd5:    return 36;
         default: return 1;
      endcase
   endfunction

   function automatic logic [GRAY_MAX_W-1:0] to_gray(input logic [GRAY_MAX_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [GRAY_MAX_W-1:0] from_gray(input logic [GRAY_MAX_W-1:0] g);
      logic [GRAY_MAX_W-1:0] b;
      b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
      for (int i = GRAY_MAX_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

endpackage

// File: rtl/wcf_sync.sv
module wcf_sync #(
   parameter int unsigned W      = 13,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wcf_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/wcf_side.sv
module wcf_side
   import wcf_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned THR_W   = 8,
   parameter bit          IS_WR   = 1'b1,
   parameter int unsigned STAGES  = 2,
   localparam int unsigned PTR_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              clr,
   input  logic [CODE_W-1:0] code,
   input  logic              req,
   input  logic [THR_W-1:0]  thr,
   input  logic [PTR_W-1:0]  far_gray,
   output logic [PTR_W-1:0]  own_gray,
   output logic [ADDR_W-1:0] addr,
   output logic              fire,
   output logic              flag_main,
   output logic              flag_almost
);
   localparam logic CLR_FLAG = IS_WR ? 1'b0 : 1'b1;

   logic [PTR_W-1:0] ptr_q, ptr_nxt, far_sync, far_bin;
   logic [PTR_W-1:0] depth_v, span_mask, occ_nxt;
   logic             main_nxt, almost_nxt;
   int unsigned      lg;

   wcf_sync #(.W(PTR_W), .STAGES(STAGES)) u_sync (
      .clk (clk),
      .clr (clr),
      .d   (far_gray),
      .q   (far_sync)
   );

   always_comb begin
      lg        = depth_lg(code, ADDR_W);
      depth_v   = PTR_W'(1) << lg;
      span_mask = (depth_v << 1) - PTR_W'(1);
      far_bin   = PTR_W'(from_gray(GRAY_MAX_W'(far_sync)));
      fire      = req && !flag_main;
      ptr_nxt   = fire ? ((ptr_q + PTR_W'(1)) & span_mask) : ptr_q;
   end

   generate
      if (IS_WR) begin : g_wr
         always_comb begin
            occ_nxt    = (ptr_nxt - far_bin) & span_mask;
            main_nxt   = (occ_nxt == depth_v);
            almost_nxt = ((depth_v - occ_nxt) <= PTR_W'(thr));
         end
      end else begin : g_rd
         always_comb begin
            occ_nxt    = (far_bin - ptr_nxt) & span_mask;
            main_nxt   = (occ_nxt == '0);
            almost_nxt = (occ_nxt <= PTR_W'(thr));
         end
      end
   endgenerate

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         ptr_q       <= '0;
         own_gray    <= '0;
         flag_main   <= CLR_FLAG;
         flag_almost <= CLR_FLAG;
      end else begin
         ptr_q       <= ptr_nxt;
         own_gray    <= PTR_W'(to_gray(GRAY_MAX_W'(ptr_nxt)));
         flag_main   <= main_nxt;
         flag_almost <= almost_nxt;
      end
   end

   assign addr = ptr_q[ADDR_W-1:0] & ADDR_W'(depth_v - PTR_W'(1));
endmodule

// File: rtl/wcf_mem.sv
module wcf_mem #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 36,
   localparam int unsigned WORDS = 1 << ADDR_W
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rclk,
   input  logic              clr,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   input  logic [DATA_W-1:0] lane_mask,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] arr [WORDS];

   always_ff @(posedge wclk) begin
      if (we) arr[waddr] <= wdata & lane_mask;
   end

   always_ff @(posedge rclk or posedge clr) begin
      if (clr)     rdata <= '0;
      else if (re) rdata <= arr[raddr] & lane_mask;
   end
endmodule

// File: rtl/wcfifo.sv
module wcfifo
   import wcf_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 36,
   parameter int unsigned THR_W  = 8,
   parameter int unsigned STAGES = 2,
   localparam int unsigned PTR_W = ADDR_W + 1
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              clr,
   input  logic [2:0]        width_code,
   input  logic [THR_W-1:0]  af_level,
   input  logic [THR_W-1:0]  ae_level,
   input  logic              wen,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ren,
   output logic [DATA_W-1:0] rdata,
   output logic              full,
   output logic              afull,
   output logic              empty,
   output logic              aempty
);
   generate
      if (DATA_W < 36) begin : g_bad_data
         $error("wcfifo needs DATA_W of at least 36");
      end
      if (ADDR_W < 6 || ADDR_W < THR_W) begin : g_bad_addr
         $error("wcfifo needs ADDR_W >= 6 and >= THR_W");
      end
   endgenerate

   logic [PTR_W-1:0]  w_gray, r_gray;
   logic [ADDR_W-1:0] w_addr, r_addr;
   logic              w_fire, r_fire;
   logic [DATA_W-1:0] lane_mask;

   always_comb lane_mask = (DATA_W'(1) << word_bits(width_code)) - DATA_W'(1);

   wcf_side #(.ADDR_W(ADDR_W), .THR_W(THR_W), .IS_WR(1'b1), .STAGES(STAGES)) u_wr (
      .clk         (wclk),
      .clr         (clr),
      .code        (width_code),
      .req         (wen),
      .thr         (af_level),
      .far_gray    (r_gray),
      .own_gray    (w_gray),
      .addr        (w_addr),
      .fire        (w_fire),
      .flag_main   (full),
      .flag_almost (afull)
   );

   wcf_side #(.ADDR_W(ADDR_W), .THR_W(THR_W), .IS_WR(1'b0), .STAGES(STAGES)) u_rd (
      .clk         (rclk),
      .clr         (clr),
      .code        (width_code),
      .req         (ren),
      .thr         (ae_level),
      .far_gray    (w_gray),
      .own_gray    (r_gray),
      .addr        (r_addr),
      .fire        (r_fire),
      .flag_main   (empty),
      .flag_almost (aempty)
   );

   wcf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .wclk      (wclk),
      .we        (w_fire),
      .waddr     (w_addr),
      .wdata     (wdata),
      .rclk      (rclk),
      .clr       (clr),
      .re        (r_fire),
      .raddr     (r_addr),
      .lane_mask (lane_mask),
      .rdata     (rdata)
   );
endmodule

// File: rtl/wcf_checker.sv
module wcf_checker
   import wcf_pkg::*;
#(
   parameter int unsigned PTR_W  = 13,
   parameter int unsigned DATA_W = 36
) (
   input logic              wclk,
   input logic              rclk,
   input logic              clr,
   input logic [2:0]        width_code,
   input logic              wen,
   input logic              ren,
   input logic              full,
   input logic              afull,
   input logic              empty,
   input logic              aempty,
   input logic [DATA_W-1:0] rdata,
   input logic [PTR_W-1:0]  w_gray,
   input logic [PTR_W-1:0]  r_gray
);
   logic [DATA_W-1:0] hi_bits;
   always_comb hi_bits = ~((DATA_W'(1) << word_bits(width_code)) - DATA_W'(1));

   assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (clr)
      (full && wen) |=> (w_gray == $past(w_gray)));

   assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (clr)
      (empty && ren) |=> (r_gray == $past(r_gray)));

   assert_wgray_step_R5: assert property (@(posedge wclk) disable iff (clr)
      $countones(w_gray ^ $past(w_gray)) <= 1);

   assert_rgray_step_R5: assert property (@(posedge rclk) disable iff (clr)
      $countones(r_gray ^ $past(r_gray)) <= 1);

   assert_rdata_lanes_R5: assert property (@(posedge rclk) disable iff (clr)
      (rdata & hi_bits) == '0);

   assert_full_implies_afull_R6: assert property (@(posedge wclk) disable iff (clr)
      full |-> afull);

   assert_empty_implies_aempty_R7: assert property (@(posedge rclk) disable iff (clr)
      empty |-> aempty);
endmodule

bind wcfifo wcf_checker #(.PTR_W(ADDR_W + 1), .DATA_W(DATA_W)) u_chk (
   .wclk       (wclk),
   .rclk       (rclk),
   .clr        (clr),
   .width_code (width_code),
   .wen        (wen),
   .ren        (ren),
   .full       (full),
   .afull      (afull),
   .empty      (empty),
   .aempty     (aempty),
   .rdata      (rdata),
   .w_gray     (w_gray),
   .r_gray     (r_gray)
);

// File: tb/wcfifo_bench.sv
module wcfifo_bench;
   logic        wclk = 1'b0;
   logic        rclk = 1'b0;
   logic        clr  = 1'b1;
   logic [2:0]  width_code = 3'd0;
   logic [7:0]  af_level = 8'd0;
   logic [7:0]  ae_level = 8'd0;
   logic        wen = 1'b0;
   logic [35:0] wdata = '0;
   logic        ren = 1'b0;
   logic [35:0] rdata;
   logic        full, afull, empty, aempty;

   int total = 0;
   int bad   = 0;

   always #10 wclk = ~wclk;
   initial begin
      #7;
      forever #15 rclk = ~rclk;
   end

   wcfifo u_wcfifo (
      .wclk(wclk), .rclk(rclk), .clr(clr), .width_code(width_code),
      .af_level(af_level), .ae_level(ae_level), .wen(wen), .wdata(wdata),
      .ren(ren), .rdata(rdata), .full(full), .afull(afull),
      .empty(empty), .aempty(aempty)
   );

   // {code[31:29], af[28:21], ae[20:13], depth[12:0]}
   localparam logic [31:0] VEC [7] = '{
      {3'd0, 8'd20,  8'd10,  13'd4096},
      {3'd1, 8'd0,   8'd0,   13'd2048},
      {3'd2, 8'd255, 8'd255, 13'd1024},
      {3'd3, 8'd5,   8'd100, 13'd512},
      {3'd4, 8'd1,   8'd7,   13'd256},
      {3'd5, 8'd127, 8'd127, 13'd128},
      {3'd6, 8'd30,  8'd3,   13'd4096}
   };

   function automatic int bits_for(input logic [2:0] c);
      case (c)
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 9;
         3'd4: return 18;
         3'd5: return 36;
         default: return 1;
      endcase
   endfunction

   function automatic logic [35:0] pat(input int n, input int c);
      logic [31:0] lo;
      lo = 32'(n) * 32'h9E37_79B1 + 32'(c) * 32'h0101_0101;
      return {4'(n) ^ 4'hA, lo};
   endfunction

   function automatic logic [35:0] lanes(input int w);
      return (36'd1 << w) - 36'd1;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic do_clear(input logic [2:0] c, input logic [7:0] af, input logic [7:0] ae);
      @(negedge wclk);
      clr = 1'b1; wen = 1'b0; ren = 1'b0;
      width_code = c; af_level = af; ae_level = ae;
      repeat (3) @(negedge wclk);
      clr = 1'b0;
      repeat (2) @(negedge rclk);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge wclk);
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge wclk);
      for (int v = 0; v < 7; v++) begin
         logic [2:0] c;
         int af, ae, dep, w, n, m, first_af, first_ae, errs;
         string tag;
         logic [35:0] hold;
         c   = VEC[v][31:29];
         af  = int'(VEC[v][28:21]);
         ae  = int'(VEC[v][20:13]);
         dep = int'(VEC[v][12:0]);
         w   = bits_for(c);
         tag = (c > 3'd5) ? "R8" : "R2";
         do_clear(c, VEC[v][28:21], VEC[v][20:13]);

         // R1: flags after clear
         chk(full == 0 && afull == 0 && empty == 1 && aempty == 1 && rdata == '0, "R1",
             "flags after clear", {full, afull, empty, aempty}, 4'b0011);

         // fill until full, reader idle
         n = 0; first_af = 0;
         @(negedge wclk);
         while (!full && n < 8192) begin
            wdata = pat(n, v); wen = 1'b1;
            @(negedge wclk);
            n++;
            if (afull && first_af == 0) first_af = n;
         end
         wen = 1'b0;
         chk(n == dep, tag, "accepted writes until full", n, dep);
         chk(first_af == dep - af && afull, "R6", "write count at afull rise", first_af, dep - af);

         // R3: write attempt against full with junk
         wdata = 36'hF_FFFF_FFFF; wen = 1'b1;
         @(negedge wclk);
         wen = 1'b0;

         repeat (8) @(negedge rclk);
         n = 0; first_ae = 0; errs = 0;
         while (!empty && n < 8192) begin
            ren = 1'b1;
            @(negedge rclk);
            if (rdata !== (pat(n, v) & lanes(w))) errs++;
            n++;
            if (aempty && first_ae == 0) first_ae = n;
         end
         ren = 1'b0;
         m = n;
         chk(m == dep, "R3", "words drained after write-on-full", m, dep);
         chk(errs == 0, "R5", "data order and width mask mismatches", errs, 0);
         chk(first_ae == dep - ae, "R7", "read count at aempty rise", first_ae, dep - ae);

         // R4: read while empty
         hold = rdata;
         ren = 1'b1;
         repeat (3) @(negedge rclk);
         ren = 1'b0;
         @(negedge rclk);
         chk(rdata == hold && empty == 1, "R4", "rdata after reads on empty",
             longint'(rdata), longint'(hold));
      end

      // R1: clear in the middle of traffic discards old words
      do_clear(3'd4, 8'd10, 8'd2);
      for (int k = 0; k < 3; k++) begin
         wdata = pat(100 + k, 0); wen = 1'b1;
         @(negedge wclk);
      end
      wen = 1'b0;
      repeat (8) @(negedge rclk);
      do_clear(3'd4, 8'd10, 8'd2);
      chk(empty == 1 && aempty == 1 && full == 0 && afull == 0, "R1",
          "flags after mid-traffic clear", {full, afull, empty, aempty}, 4'b0011);

      // R9: one write reaches the read side within five read edges
      @(negedge wclk);
      wdata = 36'h1_2345_6789; wen = 1'b1;
      @(posedge wclk);
      #2 wen = 1'b0;
      repeat (5) @(posedge rclk);
      #1;
      chk(empty == 0, "R9", "empty five read edges after write", empty, 0);
      @(negedge rclk);
      ren = 1'b1;
      @(negedge rclk);
      ren = 1'b0;
      chk(rdata == (36'h1_2345_6789 & lanes(18)), "R1", "first word after clear",
          longint'(rdata), longint'(36'h1_2345_6789 & lanes(18)));
      chk(empty == 1, "R4", "empty after single read", empty, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule